// File: doc/BRIEF.md
# SHA-256 Block Compression Engine

This block runs the SHA-256 compression function on one 512-bit message block at a time. It returns the 256-bit chaining value that results from that block. The caller supplies the block, a start pulse and a flag that selects the starting chaining value. With the flag set, the engine starts from the standard initial hash value. With the flag clear, it starts from the value on `hash_in`. Message padding and block splitting are done outside the engine. A longer message is hashed by feeding each `hash_out` back into `hash_in` for the next block.

Inside, a sliding 16-word window produces the message schedule serially, one word per round. The 64 rounds use carry-save reduction with a single carry-propagate add per result. One register stage precomputes the next round's `H + K + W` term, and a source multiplexer selects whether that term is fed from the loaded state or from the running state. Every block takes the same fixed number of cycles.

Top module: `sha256_block_engine`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `done` and `busy` are 0 and `hash_out` is all zeros.
- R2: With `first` = 0, the result equals the SHA-256 compression of `block` using `hash_in` as the chaining value. Word 0 of the block is `block[511:480]` and word 15 is `block[31:0]`. Chaining word A is `hash_in[255:224]` and word H is `hash_in[31:0]`. `hash_out` uses the same word order.
- R3: With `first` = 1, the chaining value is the standard SHA-256 initial hash, and `hash_in` has no effect on the result.
- R4: `done` is high for exactly one cycle. It goes high 67 cycles after the cycle in which `start` was accepted, and the new `hash_out` is valid in that same cycle.
- R5: A `start` pulse while `busy` is high is ignored. It produces no extra `done` and does not change the result of the block in progress.
- R6: `start` is accepted when `busy` is low. `busy` goes high in the cycle after acceptance and stays high until the `done` cycle, in which it is low. A new block may therefore be started in the `done` cycle.
- R7: `hash_out` keeps its value from one `done` pulse until the next.
- R8: `block`, `hash_in` and `first` are sampled only in the accepting cycle. Changing them while `busy` is high has no effect on the result.
- R9: Feeding `hash_out` back as `hash_in` with `first` = 0 for the following block yields the standard multi-block digest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block when idle |
| first | input | 1 | 1: start from the standard initial hash; 0: start from `hash_in` |
| block | input | 512 | Message block, word 0 in the top bits |
| hash_in | input | 256 | Incoming chaining value, word A in the top bits |
| hash_out | output | 256 | Resulting chaining value, registered |
| done | output | 1 | One-cycle result strobe |
| busy | output | 1 | Block in progress |

## Verification
Take the cycle in which `start` is accepted as cycle 0. `busy` is due in cycle 1, and `done` with the new `hash_out` is due in cycle 67. The next `start` may then be accepted in that same cycle 67. The bench drives inputs on falling edges and records the due cycle of each issued block in a scoreboard entry. The monitor samples on falling edges and checks every `done` against the head entry's due cycle and digest. Any `done` without a pending entry, or lasting two cycles, counts as a failure. This is how ignored starts and premature or late results are caught.

// File: rtl/sha256_pkg.sv
package sha256_pkg;

  localparam int WORD_W     = 32;
  localparam int HASH_WORDS = 8;
  localparam int BLK_WORDS  = 16;
  localparam int ROUNDS     = 64;
  localparam int HASH_W     = WORD_W * HASH_WORDS;
  localparam int BLK_W      = WORD_W * BLK_WORDS;
  localparam int RND_W      = $clog2(ROUNDS);
  localparam int CNT_W      = $clog2(ROUNDS + 2) + 1;
  localparam int LATENCY    = ROUNDS + 3;

  typedef logic [WORD_W-1:0] word_t;

  // carry-save pair: value = s + c
  typedef struct packed {
    word_t s;
    word_t c;
  } csa_t;

  localparam logic [HASH_W-1:0] INIT_HASH = {
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19
  };

  function automatic csa_t csa3(word_t a, word_t b, word_t c);
    csa_t r;
    r.s = a ^ b ^ c;
    r.c = ((a & b) | (a & c) | (b & c)) << 1;
    return r;
  endfunction

  function automatic word_t rotr(word_t x, int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t bsig0(word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t bsig1(word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t ssig0(word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t ssig1(word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t f_choose(word_t e, word_t f, word_t g);
    return (e & f) ^ (~e & g);
  endfunction

  function automatic word_t f_major(word_t a, word_t b, word_t c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction

  function automatic word_t round_const(logic [RND_W-1:0] i);
    word_t k;
    case (i)
      6'd0:  k = 32'h428a2f98; 6'd1:  k = 32'h71374491; 6'd2:  k = 32'hb5c0fbcf; 6'd3:  k = 32'he9b5dba5;
      6'd4:  k = 32'h3956c25b; 6'd5:  k = 32'h59f111f1; 6'd6:  k = 32'h923f82a4; 6'd7:  k = 32'hab1c5ed5;
      6'd8:  k = 32'hd807aa98; 6'd9:  k = 32'h12835b01; 6'd10: k = 32'h243185be; 6'd11: k = 32'h550c7dc3;
      6'd12: k = 32'h72be5d74; 6'd13: k = 32'h80deb1fe; 6'd14: k = 32'h9bdc06a7; 6'd15: k = 32'hc19bf174;
      6'd16: k = 32'he49b69c1; 6'd17: k = 32'hefbe4786; 6'd18: k = 32'h0fc19dc6; 6'd19: k = 32'h240ca1cc;
      6'd20: k = 32'h2de92c6f; 6'd21: k = 32'h4a7484aa; 6'd22: k = 32'h5cb0a9dc; 6'd23: k = 32'h76f988da;
      6'd24: k = 32'h983e5152; 6'd25: k = 32'ha831c66d; 6'd26: k = 32'hb00327c8; 6'd27: k = 32'hbf597fc7;
      6'd28: k = 32'hc6e00bf3; 6'd29: k = 32'hd5a79147; 6'd30: k = 32'h06ca6351; 6'd31: k = 32'h14292967;
      6'd32: k = 32'h27b70a85; 6'd33: k = 32'h2e1b2138; 6'd34: k = 32'h4d2c6dfc; 6'd35: k = 32'h53380d13;
      6'd36: k = 32'h650a7354; 6'd37: k = 32'h766a0abb; 6'd38: k = 32'h81c2c92e; 6'd39: k = 32'h92722c85;
      6'd40: k = 32'ha2bfe8a1; 6'd41: k = 32'ha81a664b; 6'd42: k = 32'hc24b8b70; 6'd43: k = 32'hc76c51a3;
      6'd44: k = 32'hd192e819; 6'd45: k = 32'hd6990624; 6'd46: k = 32'hf40e3585; 6'd47: k = 32'h106aa070;
      6'd48: k = 32'h19a4c116; 6'd49: k = 32'h1e376c08; 6'd50: k = 32'h2748774c; 6'd51: k = 32'h34b0bcb5;
      6'd52: k = 32'h391c0cb3; 6'd53: k = 32'h4ed8aa4a; 6'd54: k = 32'h5b9cca4f; 6'd55: k = 32'h682e6ff3;
      6'd56: k = 32'h748f82ee; 6'd57: k = 32'h78a5636f; 6'd58: k = 32'h84c87814; 6'd59: k = 32'h8cc70208;
      6'd60: k = 32'h90befffa; 6'd61: k = 32'ha4506ceb; 6'd62: k = 32'hbef9a3f7; default: k = 32'hc67178f2;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/sha256_sched.sv
module sha256_sched
  import sha256_pkg::*;
(
  input  logic             clk,
  input  logic             load,
  input  logic             step,
  input  logic [BLK_W-1:0] blk,
  output word_t            w_next
);

  word_t win [BLK_WORDS];
  csa_t  lvl1, lvl2;
  word_t w_new;

  // W[t+16] = ssig1(W[t+14]) + W[t+9] + ssig0(W[t+1]) + W[t]
  always_comb begin
    lvl1  = csa3(ssig1(win[14]), win[9], ssig0(win[1]));
    lvl2  = csa3(lvl1.s, lvl1.c, win[0]);
    w_new = lvl2.s + lvl2.c;
  end

  assign w_next = win[1];

  for (genvar i = 0; i < BLK_WORDS; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (load) begin
        win[i] <= blk[BLK_W-1-WORD_W*i -: WORD_W];
      end else if (step) begin
        if (i == BLK_WORDS - 1) begin
          win[i] <= w_new;
        end else begin
          win[i] <= win[(i + 1) % BLK_WORDS];
        end
      end
    end
  end

endmodule

// File: rtl/sha256_round.sv
module sha256_round
  import sha256_pkg::*;
(
  input  logic              clk,
  input  logic              load,
  input  logic              step,
  input  logic [RND_W-1:0]  rnd,
  input  logic [HASH_W-1:0] init_state,
  input  word_t             blk_w0,
  input  word_t             w_next,
  output logic [HASH_W-1:0] state
);

  word_t ra, rb, rc, rd, re, rf, rg, rh;
  word_t pre;              // registered H + K[t] + W[t] for the current round
  word_t pa, pb, pc, pre_nxt;
  csa_t  pre_cs;
  csa_t  t1_cs, e_cs, a_cs1, a_cs2;
  word_t a_nxt, e_nxt;

  // source multiplexer for the precompute stage: loaded state vs running state
  always_comb begin
    if (load) begin
      pa = init_state[WORD_W-1:0];
      pb = round_const('0);
      pc = blk_w0;
    end else begin
      pa = rg;
      pb = round_const(rnd + 1'b1);
      pc = w_next;
    end
    pre_cs  = csa3(pa, pb, pc);
    pre_nxt = pre_cs.s + pre_cs.c;
  end

  always_comb begin
    t1_cs = csa3(pre, bsig1(re), f_choose(re, rf, rg));
    e_cs  = csa3(t1_cs.s, t1_cs.c, rd);
    e_nxt = e_cs.s + e_cs.c;
    a_cs1 = csa3(t1_cs.s, t1_cs.c, bsig0(ra));
    a_cs2 = csa3(a_cs1.s, a_cs1.c, f_major(ra, rb, rc));
    a_nxt = a_cs2.s + a_cs2.c;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      {ra, rb, rc, rd, re, rf, rg, rh} <= init_state;
      pre <= pre_nxt;
    end else if (step) begin
      ra  <= a_nxt;
      rb  <= ra;
      rc  <= rb;
      rd  <= rc;
      re  <= e_nxt;
      rf  <= re;
      rg  <= rf;
      rh  <= rg;
      pre <= pre_nxt;
    end
  end

  assign state = {ra, rb, rc, rd, re, rf, rg, rh};

endmodule

// File: rtl/sha256_ctrl.sv
module sha256_ctrl
  import sha256_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             do_load,
  output logic             do_step,
  output logic             do_sum,
  output logic             do_out,
  output logic [RND_W-1:0] rnd
);

  localparam int unsigned SUM_AT = ROUNDS;
  localparam int unsigned OUT_AT = ROUNDS + 1;

  logic [CNT_W-1:0] cnt;

  assign do_load = start && !busy;
  assign do_step = busy && (cnt < CNT_W'(SUM_AT));
  assign do_sum  = busy && (cnt == CNT_W'(SUM_AT));
  assign do_out  = busy && (cnt == CNT_W'(OUT_AT));
  assign rnd     = cnt[RND_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= '0;
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(OUT_AT)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sha256_fold.sv
module sha256_fold
  import sha256_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sum_en,
  input  logic              out_en,
  input  logic [HASH_W-1:0] init_state,
  input  logic [HASH_W-1:0] work_state,
  output logic [HASH_W-1:0] hash_out
);

  logic [HASH_W-1:0] sum_q;

  for (genvar i = 0; i < HASH_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (sum_en) begin
        sum_q[WORD_W*i +: WORD_W] <= init_state[WORD_W*i +: WORD_W] + work_state[WORD_W*i +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hash_out <= '0;
    end else if (out_en) begin
      hash_out <= sum_q;
    end
  end

endmodule

// File: rtl/sha256_block_engine.sv
module sha256_block_engine
  import sha256_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              first,
  input  logic [BLK_W-1:0]  block,
  input  logic [HASH_W-1:0] hash_in,
  output logic [HASH_W-1:0] hash_out,
  output logic              done,
  output logic              busy
);

  logic              do_load, do_step, do_sum, do_out;
  logic [RND_W-1:0]  rnd;
  logic [HASH_W-1:0] sel_init, init_q, work;
  word_t             w_next;

  assign sel_init = first ? INIT_HASH : hash_in;

  always_ff @(posedge clk) begin
    if (do_load) begin
      init_q <= sel_init;
    end
  end

  sha256_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .do_load (do_load),
    .do_step (do_step),
    .do_sum  (do_sum),
    .do_out  (do_out),
    .rnd     (rnd)
  );

  sha256_sched u_sched (
    .clk    (clk),
    .load   (do_load),
    .step   (do_step),
    .blk    (block),
    .w_next (w_next)
  );

  sha256_round u_round (
    .clk        (clk),
    .load       (do_load),
    .step       (do_step),
    .rnd        (rnd),
    .init_state (sel_init),
    .blk_w0     (block[BLK_W-1 -: WORD_W]),
    .w_next     (w_next),
    .state      (work)
  );

  sha256_fold u_fold (
    .clk        (clk),
    .rst        (rst),
    .sum_en     (do_sum),
    .out_en     (do_out),
    .init_state (init_q),
    .work_state (work),
    .hash_out   (hash_out)
  );

endmodule

// File: rtl/sha256_block_engine_chk.sv
module sha256_block_engine_chk
  import sha256_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [HASH_W-1:0] hash_out
);

  logic [7:0] since_acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_acc <= '0;
    end else if (start && !busy) begin
      since_acc <= 8'd1;
    end else if (done) begin
      since_acc <= '0;
    end else if (since_acc != '0 && since_acc != 8'hff) begin
      since_acc <= since_acc + 1'b1;
    end
  end

  // R4: single-cycle strobe
  p_done_single_r4: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R4: strobe lands at the fixed latency
  p_done_latency_r4: assert property (@(posedge clk) disable iff (rst) done |-> (since_acc == 8'(LATENCY)));

  // R6: accepted start raises busy
  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);

  // R6: idle in the strobe cycle
  p_idle_at_done_r6: assert property (@(posedge clk) disable iff (rst) done |-> !busy);

  // R7: result only moves with the strobe
  p_hold_result_r7: assert property (@(posedge clk) disable iff (rst) !$stable(hash_out) |-> done);

endmodule

bind sha256_block_engine sha256_block_engine_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .hash_out (hash_out)
);

// File: tb/sha256_block_engine_test.sv
`timescale 1ns/1ps
module sha256_block_engine_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         first = 1'b0;
  logic [511:0] block = '0;
  logic [255:0] hash_in = '0;
  logic [255:0] hash_out;
  logic         done;
  logic         busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit prev_done = 0;

  logic [255:0] q_val [$];
  bit           q_chk [$];
  int           q_due [$];
  string        q_tag [$];

  localparam logic [255:0] IV_WORDS = {
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
  localparam logic [511:0] BLK_ABC = {32'h61626380, 448'h0, 32'h00000018};
  localparam logic [255:0] DIG_ABC = 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
  localparam logic [511:0] BLK_EMPTY = {32'h80000000, 480'h0};
  localparam logic [255:0] DIG_EMPTY = 256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855;
  localparam logic [511:0] BLK_LONG1 = {
    32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667,
    32'h65666768, 32'h66676869, 32'h6768696a, 32'h68696a6b,
    32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
    32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000};
  localparam logic [511:0] BLK_LONG2 = {480'h0, 32'h000001c0};
  localparam logic [255:0] DIG_LONG = 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1;

  sha256_block_engine uut (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .first    (first),
    .block    (block),
    .hash_in  (hash_in),
    .hash_out (hash_out),
    .done     (done),
    .busy     (busy)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (done && prev_done) check(1'b0, "R4", "done held two cycles", 256'd1, 256'd0);
      if (done) begin
        if (q_val.size() == 0) begin
          check(1'b0, "R5", "done with no pending block", hash_out, 256'd0);
        end else begin
          automatic logic [255:0] v = q_val.pop_front();
          automatic bit           c = q_chk.pop_front();
          automatic int           d = q_due.pop_front();
          automatic string        t = q_tag.pop_front();
          if (c) check(hash_out == v, t, "digest", hash_out, v);
          check(cyc == d, "R4", "done cycle", 256'(cyc), 256'(d));
        end
      end
      prev_done = done;
    end
  end

  // driver
  task automatic issue(input logic [511:0] b, input logic [255:0] h, input bit f,
                       input bit chk, input logic [255:0] exp, input string tag,
                       input bit scramble);
    @(negedge clk);
    while (busy) @(negedge clk);
    block   = b;
    hash_in = h;
    first   = f;
    start   = 1'b1;
    q_val.push_back(exp);
    q_chk.push_back(chk);
    q_due.push_back(cyc + 67);
    q_tag.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R6", "busy after accept", 256'(busy), 256'd1);
    if (scramble) begin
      // R5 R8: new starts and changed inputs while running
      block   = ~b;
      hash_in = ~h;
      first   = ~f;
      repeat (10) begin
        start = 1'b1;
        @(negedge clk);
      end
      start = 1'b0;
      check(busy == 1'b1, "R5", "still running after ignored starts", 256'(busy), 256'd1);
    end
  endtask

  task automatic wait_idle();
    while (q_val.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog expired: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [255:0] mid;
    logic [255:0] held;
    repeat (4) @(negedge clk);
    check(done == 1'b0, "R1", "done in reset", 256'(done), 256'd0);
    check(busy == 1'b0, "R1", "busy in reset", 256'(busy), 256'd0);
    rst = 1'b0;
    @(negedge clk);
    check(hash_out == '0, "R1", "hash_out after reset", hash_out, 256'd0);
    check(busy == 1'b0 && done == 1'b0, "R1", "idle after reset", {busy, done}, 256'd0);

    // R3 R5 R8: initial hash used, garbage hash_in and mid-run activity ignored
    issue(BLK_ABC, {8{32'hdeadbeef}}, 1'b1, 1'b1, DIG_ABC, "R3 R5 R8 abc", 1'b1);
    wait_idle();

    // R7: result holds while idle
    held = hash_out;
    repeat (20) @(negedge clk);
    check(hash_out == held, "R7", "hash_out held", hash_out, held);
    check(done == 1'b0, "R7", "no stray done", 256'(done), 256'd0);

    // R2: empty message, then R6: next block starts in the done cycle
    issue(BLK_EMPTY, '0, 1'b1, 1'b1, DIG_EMPTY, "R2 empty", 1'b0);
    issue(BLK_LONG1, '0, 1'b1, 1'b0, '0, "R6 back-to-back", 1'b0);
    wait_idle();
    mid = hash_out;

    // R9: chained second block
    issue(BLK_LONG2, mid, 1'b0, 1'b1, DIG_LONG, "R9 two-block", 1'b0);
    wait_idle();
    check(hash_out == DIG_LONG, "R9", "chained digest held", hash_out, DIG_LONG);

    // R2: explicit chaining value equal to the initial hash
    issue(BLK_ABC, IV_WORDS, 1'b0, 1'b1, DIG_ABC, "R2 explicit chain", 1'b0);
    wait_idle();
    check(busy == 1'b0, "R6", "idle after result", 256'(busy), 256'd0);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule